// File: doc/BRIEF.md
# Flash Command-Mode and Status Register

This block sits between a host bus and the internals of a page-mode flash device. The host uses active-low chip-enable, output-enable and write-enable strobes. A write of a command byte chooses what later reads return: the array contents, an 8-bit status register, or the two silicon identification codes. The erase and program commands also switch reads to status, so that the host can poll for completion. They also send a request pulse to the embedded write state machine.

The status register holds these bits:
- bit 7: a ready flag.
- bit 6: a suspend flag.
- bit 5: a sticky erase-fail bit.
- bit 4: a sticky program-fail bit.
- bit 3: a sector-protect mirror.
- bit 2: a sleep/abort flag.

The write state machine is modelled by a few level and pulse inputs. Read data is captured once per read cycle, on the clock edge where the later of the two read strobes is first seen low. The value then holds until the strobes are released. The output is formatted for either byte-wide or word-wide operation.

All strobes are synchronous to `clk`. A command is taken on the clock edge that first sees `weN` high again after a low phase, while `ceN` is low. The command byte is taken from `dataIn`.

Top module: `flashcmd_top`

## Requirements
- R1: After reset the status register reads 80h (ready=1, all other bits 0), and reads return array data.
- R2: Command 70h makes every later read return status until another recognised mode command is written. Command 00h or FFh returns reads to array data.
- R3: Commands 20h (sector erase), 30h (chip erase) and 40h (page program) switch reads to status. When accepted, they pulse `eraseReq` (with `chipErase`=1 for 30h) or `progReq` for one clock, starting the cycle after the command edge.
- R4: A status read returns the status byte on bits 7:2, with bits 1:0 at 0 and bits 15:8 at 00h. In word mode `dataOe` is FFFFh during a read. In byte mode it is 00FFh, so bits 14:8 are tri-stated and bit 15 is left as an address input.
- R5: Read data is captured on the edge where `ceN` and `oeN` are first both seen low. It stays constant while both remain low, even if the status changes. A fresh read cycle shows the new value.
- R6: Status bit 7 is the inverse of `wsmBusy`, and bit 6 follows `wsmSuspend`. Each lags its input by one clock.
- R7: Status bit 5 is set by a `wsmEraseFail` pulse and bit 4 by a `wsmProgFail` pulse. Both stay set through every command except 50h, which clears them both without changing the read mode.
- R8: While status bit 4 or bit 5 is set, the commands 20h, 30h and 40h raise no request pulse.
- R9: Status bit 3 mirrors `sectorProt` with a one-clock lag. No command changes it.
- R10: Status bit 2 is set by a `sleepAbort` pulse. Only the 00h/FFh command clears it.
- R11: Command 90h makes reads return C2h when `addrLsb`=0 and F7h when `addrLsb`=1, with bits 15:8 at 00h.
- R12: A command code outside 00h, FFh, 20h, 30h, 40h, 50h, 70h and 90h leaves the read mode unchanged.
- R13: In byte mode, an array read returns `arrayData[7:0]` when `addrM1`=0 and `arrayData[15:8]` when `addrM1`=1, on bits 7:0 with bits 15:8 at 0. In word mode it returns all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low; command taken on its return high |
| byteMode | input | 1 | 1 selects byte-wide output formatting |
| addrLsb | input | 1 | Selects manufacturer (0) or device (1) code in ID mode |
| addrM1 | input | 1 | Byte select for byte-wide array reads |
| dataIn | input | 8 | Command byte |
| arrayData | input | 16 | Word from the array at the current address |
| wsmBusy | input | 1 | Write state machine busy |
| wsmSuspend | input | 1 | Operation suspended |
| wsmEraseFail | input | 1 | Erase failure pulse |
| wsmProgFail | input | 1 | Program failure pulse |
| sectorProt | input | 1 | Sector-protect state of the addressed sector |
| sleepAbort | input | 1 | Sleep or abort event pulse |
| dataOut | output | 16 | Captured read data |
| dataOe | output | 16 | Per-bit output enable |
| eraseReq | output | 1 | One-clock erase request |
| chipErase | output | 1 | Qualifies eraseReq as whole-chip erase |
| progReq | output | 1 | One-clock page-program request |

## Verification
The assertions assume that strobe changes are seen by the clock, with `ceN` held low across the rising edge of `weN`. They also assume that a failure pulse and a 50h command are never seen on the same edge. The bench drives every strobe, command byte and event pulse on the falling clock edge. Each command write uses the sequence ce-low with we-low, then we-high, then ce-high, one clock apart. Failure pulses always go out well apart from clear commands. This keeps every capture and command edge unambiguous.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] CMD_ARRAY_A   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_ARRAY_B   = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_STATUS    = 8'h70;
  localparam logic [BYTE_W-1:0] CMD_CLEAR     = 8'h50;
  localparam logic [BYTE_W-1:0] CMD_IDENT     = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_ERASE_SEC = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_ERASE_ALL = 8'h30;
  localparam logic [BYTE_W-1:0] CMD_PROGRAM   = 8'h40;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } readMode_t;

  typedef struct packed {
    logic latchRead;
    logic clearFails;
    logic clearSleep;
  } ctlStrobe_t;
endpackage

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              failAny,
  output readMode_t         readMode,
  output ctlStrobe_t        strobe,
  output logic              readActive,
  output logic              eraseReq,
  output logic              chipErase,
  output logic              progReq
);
  logic weNPrev;
  logic readPrev;
  logic cmdTake;
  readMode_t modeNext;
  logic isErase, isChip, isProg;

  assign readActive = !ceN && !oeN;
  assign cmdTake    = weN && !weNPrev && !ceN;

  assign isChip  = (dataIn == CMD_ERASE_ALL);
  assign isErase = (dataIn == CMD_ERASE_SEC) || isChip;
  assign isProg  = (dataIn == CMD_PROGRAM);

  always_comb begin
    modeNext = readMode;
    unique case (dataIn)
      CMD_ARRAY_A, CMD_ARRAY_B:                            modeNext = MODE_ARRAY;
      CMD_STATUS, CMD_ERASE_SEC, CMD_ERASE_ALL, CMD_PROGRAM: modeNext = MODE_STATUS;
      CMD_IDENT:                                           modeNext = MODE_IDENT;
      default:                                             modeNext = readMode;
    endcase
  end

  always_comb begin
    strobe.latchRead  = readActive && !readPrev;
    strobe.clearFails = cmdTake && (dataIn == CMD_CLEAR);
    strobe.clearSleep = cmdTake && ((dataIn == CMD_ARRAY_A) || (dataIn == CMD_ARRAY_B));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNPrev   <= 1'b1;
      readPrev  <= 1'b0;
      readMode  <= MODE_ARRAY;
      eraseReq  <= 1'b0;
      chipErase <= 1'b0;
      progReq   <= 1'b0;
    end else begin
      weNPrev   <= weN;
      readPrev  <= readActive;
      eraseReq  <= cmdTake && isErase && !failAny;
      chipErase <= cmdTake && isChip && !failAny;
      progReq   <= cmdTake && isProg && !failAny;
      if (cmdTake) readMode <= modeNext;
    end
  end
endmodule

// File: rtl/flashcmd_dpath.sv
module flashcmd_dpath
  import flashcmd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  readMode_t         readMode,
  input  logic              readActive,
  input  logic              byteMode,
  input  logic              addrLsb,
  input  logic              addrM1,
  input  logic [WORD_W-1:0] arrayData,
  input  logic              wsmBusy,
  input  logic              wsmSuspend,
  input  logic              wsmEraseFail,
  input  logic              wsmProgFail,
  input  logic              sectorProt,
  input  logic              sleepAbort,
  output logic [BYTE_W-1:0] statReg,
  output logic              failAny,
  output logic [WORD_W-1:0] dataOut,
  output logic [WORD_W-1:0] dataOe
);
  logic rdyQ, suspQ, eFailQ, pFailQ, protQ, slpQ;
  logic [WORD_W-1:0] fmtWord;
  logic [BYTE_W-1:0] fmtByte;

  assign statReg = {rdyQ, suspQ, eFailQ, pFailQ, protQ, slpQ, 2'b00};
  assign failAny = eFailQ || pFailQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyQ   <= 1'b1;
      suspQ  <= 1'b0;
      eFailQ <= 1'b0;
      pFailQ <= 1'b0;
      protQ  <= 1'b0;
      slpQ   <= 1'b0;
    end else begin
      rdyQ  <= !wsmBusy;
      suspQ <= wsmSuspend;
      protQ <= sectorProt;
      if (strobe.clearFails) begin
        eFailQ <= 1'b0;
        pFailQ <= 1'b0;
      end
      if (wsmEraseFail) eFailQ <= 1'b1;
      if (wsmProgFail)  pFailQ <= 1'b1;
      if (strobe.clearSleep) slpQ <= 1'b0;
      if (sleepAbort)        slpQ <= 1'b1;
    end
  end

  always_comb begin
    fmtByte = addrM1 ? arrayData[WORD_W-1:BYTE_W] : arrayData[BYTE_W-1:0];
    unique case (readMode)
      MODE_STATUS: fmtWord = {{BYTE_W{1'b0}}, statReg};
      MODE_IDENT:  fmtWord = {{BYTE_W{1'b0}}, (addrLsb ? DEV_CODE : MFR_CODE)};
      default:     fmtWord = byteMode ? {{BYTE_W{1'b0}}, fmtByte} : arrayData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dataOut <= '0;
    else if (strobe.latchRead) dataOut <= fmtWord;
  end

  always_comb begin
    if (!readActive)   dataOe = '0;
    else if (byteMode) dataOe = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    else               dataOe = '1;
  end
endmodule

// File: rtl/flashcmd_top.sv
module flashcmd_top
  import flashcmd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        byteMode,
  input  logic        addrLsb,
  input  logic        addrM1,
  input  logic [7:0]  dataIn,
  input  logic [15:0] arrayData,
  input  logic        wsmBusy,
  input  logic        wsmSuspend,
  input  logic        wsmEraseFail,
  input  logic        wsmProgFail,
  input  logic        sectorProt,
  input  logic        sleepAbort,
  output logic [15:0] dataOut,
  output logic [15:0] dataOe,
  output logic        eraseReq,
  output logic        chipErase,
  output logic        progReq
);
  readMode_t  readMode;
  ctlStrobe_t strobe;
  logic       readActive;
  logic       failAny;
  logic [7:0] statReg;

  flashcmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .dataIn(dataIn), .failAny(failAny), .readMode(readMode),
    .strobe(strobe), .readActive(readActive),
    .eraseReq(eraseReq), .chipErase(chipErase), .progReq(progReq)
  );

  flashcmd_dpath #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readMode(readMode),
    .readActive(readActive), .byteMode(byteMode), .addrLsb(addrLsb),
    .addrM1(addrM1), .arrayData(arrayData), .wsmBusy(wsmBusy),
    .wsmSuspend(wsmSuspend), .wsmEraseFail(wsmEraseFail),
    .wsmProgFail(wsmProgFail), .sectorProt(sectorProt),
    .sleepAbort(sleepAbort), .statReg(statReg), .failAny(failAny),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/flashcmd_chk.sv
module flashcmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ceN,
  input logic        oeN,
  input logic        byteMode,
  input logic        sectorProt,
  input logic [7:0]  statReg,
  input logic        clearFails,
  input logic        eraseReq,
  input logic        progReq,
  input logic [15:0] dataOut,
  input logic [15:0] dataOe
);
  logic readOn;
  assign readOn = !ceN && !oeN;

  AST_NO_REQ_ON_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq || progReq) |-> ($past(statReg[5:4]) == 2'b00)); // R8

  AST_PFAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statReg[4] && !clearFails) |=> statReg[4]); // R7

  AST_EFAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statReg[5] && !clearFails) |=> statReg[5]); // R7

  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (readOn && $past(readOn)) |=> $stable(dataOut)); // R5

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    byteMode |-> (dataOe[15:8] == 8'h00)); // R4

  AST_PROT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    sectorProt |=> statReg[3]); // R9
endmodule

bind flashcmd_top flashcmd_chk chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .byteMode(byteMode),
  .sectorProt(sectorProt), .statReg(statReg),
  .clearFails(strobe.clearFails), .eraseReq(eraseReq), .progReq(progReq),
  .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/flashcmd_tb.sv
module flashcmd_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic byteMode = 1'b0, addrLsb = 1'b0, addrM1 = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [15:0] arrayData = 16'h0000;
  logic wsmBusy = 1'b0, wsmSuspend = 1'b0, wsmEraseFail = 1'b0;
  logic wsmProgFail = 1'b0, sectorProt = 1'b0, sleepAbort = 1'b0;
  logic [15:0] dataOut, dataOe;
  logic eraseReq, chipErase, progReq;

  int nVec = 0, nBad = 0;
  int eraseCnt = 0, progCnt = 0, chipCnt = 0;
  bit finished = 1'b0;
  logic [15:0] rd, oe;

  always #4 clk = ~clk;

  flashcmd_top dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .byteMode(byteMode), .addrLsb(addrLsb), .addrM1(addrM1),
    .dataIn(dataIn), .arrayData(arrayData), .wsmBusy(wsmBusy),
    .wsmSuspend(wsmSuspend), .wsmEraseFail(wsmEraseFail),
    .wsmProgFail(wsmProgFail), .sectorProt(sectorProt),
    .sleepAbort(sleepAbort), .dataOut(dataOut), .dataOe(dataOe),
    .eraseReq(eraseReq), .chipErase(chipErase), .progReq(progReq)
  );

  always @(negedge clk) begin
    if (eraseReq) eraseCnt++;
    if (progReq) progCnt++;
    if (chipErase) chipCnt++;
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] code);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; dataIn = code;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readOnce(output logic [15:0] d, output logic [15:0] e);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); d = dataOut; e = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] statExp(input bit busy, input bit susp, input bit ef,
                                          input bit pf, input bit pr, input bit sl);
    return {8'h00, ~busy, susp, ef, pf, pr, sl, 2'b00};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++; nVec++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 idle dataOe", dataOe, 16'h0000);
    // R1: reset mode is array
    arrayData = 16'hA55A;
    readOnce(rd, oe);
    check("R1 reset array read", rd, 16'hA55A);
    check("R4 word oe", oe, 16'hFFFF);
    cmd(8'h70);
    readOnce(rd, oe);
    check("R1 reset status 80h", rd, 16'h0080);

    // R2/R4/R6/R9: sweep busy, suspend, protect and width
    for (int v = 0; v < 16; v++) begin
      wsmBusy = v[0]; wsmSuspend = v[1]; sectorProt = v[2]; byteMode = v[3];
      @(negedge clk);
      readOnce(rd, oe);
      check("R6 R9 R4 status sweep", rd, statExp(v[0], v[1], 1'b0, 1'b0, v[2], 1'b0));
      check("R4 oe sweep", oe, v[3] ? 16'h00FF : 16'hFFFF);
    end
    wsmBusy = 0; wsmSuspend = 0; sectorProt = 0; byteMode = 0;
    @(negedge clk);

    // R2: back to array with 00h and FFh
    cmd(8'h00);
    arrayData = 16'h1234;
    readOnce(rd, oe);
    check("R2 array after 00h", rd, 16'h1234);
    cmd(8'h70); cmd(8'hFF);
    readOnce(rd, oe);
    check("R2 array after FFh", rd, 16'h1234);

    // R13: array byte select sweep
    for (int v = 0; v < 8; v++) begin
      byteMode = v[0]; addrM1 = v[1];
      arrayData = v[2] ? 16'hC3E1 : 16'h7F08;
      readOnce(rd, oe);
      check("R13 array format", rd,
            !v[0] ? arrayData : (v[1] ? {8'h00, arrayData[15:8]} : {8'h00, arrayData[7:0]}));
    end
    byteMode = 0; addrM1 = 0;

    // R11: ID codes
    cmd(8'h90);
    for (int v = 0; v < 4; v++) begin
      byteMode = v[0]; addrLsb = v[1];
      readOnce(rd, oe);
      check("R11 id code", rd, v[1] ? 16'h00F7 : 16'h00C2);
    end
    byteMode = 0; addrLsb = 0;

    // R12: unknown codes keep ID mode, then status mode
    cmd(8'h5A);
    readOnce(rd, oe);
    check("R12 unknown keeps id", rd, 16'h00C2);
    cmd(8'h70); cmd(8'hA7);
    readOnce(rd, oe);
    check("R12 unknown keeps status", rd, 16'h0080);

    // R5: capture at later strobe, hold within read, refresh next read
    wsmBusy = 1'b1;
    @(negedge clk); ceN = 1'b0;
    @(negedge clk);
    check("R5 no drive with oe high", dataOe, 16'h0000);
    oeN = 1'b0;
    @(negedge clk);
    check("R5 captured busy", dataOut, 16'h0000);
    wsmBusy = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 held during read", dataOut, 16'h0000);
    ceN = 1'b1; oeN = 1'b1;
    readOnce(rd, oe);
    check("R5 new read sees ready", rd, 16'h0080);

    // R3: accepted requests
    cmd(8'h00);
    eraseCnt = 0; progCnt = 0; chipCnt = 0;
    cmd(8'h20);
    check("R3 sector erase req", 16'(eraseCnt), 16'd1);
    check("R3 sector not chip", 16'(chipCnt), 16'd0);
    readOnce(rd, oe);
    check("R3 erase to status", rd, 16'h0080);
    cmd(8'h00); cmd(8'h30);
    check("R3 chip erase req", 16'(eraseCnt), 16'd2);
    check("R3 chip flag", 16'(chipCnt), 16'd1);
    cmd(8'h00); cmd(8'h40);
    check("R3 program req", 16'(progCnt), 16'd1);
    readOnce(rd, oe);
    check("R3 program to status", rd, 16'h0080);

    // R7/R8: program fail sticky and blocking
    pulse(wsmProgFail);
    readOnce(rd, oe);
    check("R7 pfail set", rd, 16'h0090);
    cmd(8'h40); cmd(8'h20); cmd(8'h30);
    check("R8 program refused", 16'(progCnt), 16'd1);
    check("R8 erase refused", 16'(eraseCnt), 16'd2);
    cmd(8'h00); cmd(8'h70);
    readOnce(rd, oe);
    check("R7 pfail survives commands", rd, 16'h0090);
    cmd(8'h00); cmd(8'h50);
    arrayData = 16'hBEEF;
    readOnce(rd, oe);
    check("R7 clear keeps array mode", rd, 16'hBEEF);
    cmd(8'h40);
    check("R8 program after clear", 16'(progCnt), 16'd2);
    readOnce(rd, oe);
    check("R7 pfail cleared", rd, 16'h0080);

    // R7/R8: erase fail
    pulse(wsmEraseFail);
    readOnce(rd, oe);
    check("R7 efail set", rd, 16'h00A0);
    cmd(8'h20); cmd(8'h40);
    check("R8 erase refused efail", 16'(eraseCnt), 16'd2);
    check("R8 program refused efail", 16'(progCnt), 16'd2);
    cmd(8'h50);
    readOnce(rd, oe);
    check("R7 efail cleared status mode", rd, 16'h0080);

    // R9: protect bit not touched by clear
    sectorProt = 1'b1;
    cmd(8'h50);
    readOnce(rd, oe);
    check("R9 protect after clear", rd, 16'h0088);
    sectorProt = 1'b0;
    @(negedge clk);

    // R10: sleep bit
    pulse(sleepAbort);
    readOnce(rd, oe);
    check("R10 sleep set", rd, 16'h0084);
    cmd(8'h50); cmd(8'h70);
    readOnce(rd, oe);
    check("R10 sleep survives clear", rd, 16'h0084);
    cmd(8'hFF); cmd(8'h70);
    readOnce(rd, oe);
    check("R10 sleep cleared by array", rd, 16'h0080);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule